// File: doc/BRIEF.md
# Scrolling Tile Background Generator

This block produces the background layer of a raster display from a tile map. The screen is 16 tiles across and 16 tiles down. Each tile is 24 pixels wide and 16 lines tall. The video scanner delivers one word slot at a time: a 6-bit horizontal word position and an 8-bit line number. The horizontal word position is a 4-bit tile column plus a 2-bit word-in-tile. The line number is a 4-bit tile row plus a 4-bit line-in-tile. The block adds a 7-bit horizontal scroll to the tile column, looks the result up in an external 2048-byte map memory, and then addresses three external byte-wide graphics memories. Those memories share one address and together return six 4-bit pixels.

Each map byte names one of 128 tile patterns and carries a mirror bit. When that bit is set, the tile is drawn mirrored left to right. The block inverts the word-in-tile index and reverses the pixel order inside the word. The six pixels are then emitted one per clock, together with a 6-bit colour bank. Colour lookup is done downstream.

Both memories are synchronous with one clock of read latency. The map read for a slot runs one slot ahead of the graphics read, and the pixels follow one slot later again.

Top module: `bg_tile_gen`

## Requirements
- R1: On a clock edge with `word_stb` high, `map_addr` becomes `{vpos[7:4], (hpos[5:2] + scroll) mod 128}`, with the row in bits 10:7.
- R2: On the strobe edge one slot after a map read, `rom_addr` becomes `{code, line, wsel}` for that slot. Here `code` is `map_data[6:0]` (bits 12:6), `line` is `vpos[3:0]` (bits 5:2) and `wsel` is `hpos[1:0]` (bits 1:0).
- R3: When the mirror bit `map_data[7]` of the fetched entry is 1, the `wsel` field of `rom_addr` is the bitwise inverse of `hpos[1:0]`.
- R4: For an unmirrored tile, the six pixels of a slot appear on `pix_index` in this order: `rom_data[23:20]`, `[19:16]`, `[15:12]`, `[11:8]`, `[7:4]`, `[3:0]`.
- R5: For a mirrored tile, the six pixels appear in the reverse order, starting with `rom_data[3:0]` and ending with `rom_data[23:20]`.
- R6: Pixels of the slot strobed at edge k appear after strobe edge k+2. `map_addr` and `rom_addr` change only on strobe edges.
- R7: `bank_sel` is captured on the strobe edge that loads a pixel word. `pix_bank` holds that value for all six pixels of the word.
- R8: After a strobe edge, `pix_index` shows pixel 0. It steps to the next pixel on each clock and holds the last pixel until the next strobe.
- R9: While `rst` is high, `map_addr`, `rom_addr`, `pix_index` and `pix_bank` are all zero.
- R10: `word_stb` is never high on two consecutive clock edges, because each memory needs a clock to answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| word_stb | input | 1 | Starts a word slot |
| hpos | input | 6 | Tile column (5:2) and word-in-tile (1:0) of the slot |
| vpos | input | 8 | Tile row (7:4) and line-in-tile (3:0) |
| scroll | input | 7 | Horizontal scroll in tiles |
| bank_sel | input | 6 | Colour bank for the word loaded at this strobe |
| map_addr | output | 11 | Map memory address |
| map_data | input | 8 | Map byte: mirror (7), tile code (6:0) |
| rom_addr | output | 13 | Shared graphics memory address |
| rom_data | input | 24 | Three graphics bytes, first-pixel byte in 23:16 |
| pix_index | output | 4 | Current background pixel colour index |
| pix_bank | output | 6 | Colour bank of the current pixel |

## Verification
The map and graphics contents come from hash functions of the address, so roughly half the fetched entries are mirrored. This tests the R3 index inversion and the R5 reverse ordering alongside the plain cases.

Random slot positions, scroll values and banks check that each slot's pixels and bank line up two slots later. Any misplaced pipeline register shows up as pixels from the wrong slot.

Directed slots push the tile column plus scroll past 127, which separates a 7-bit wrap from a wider sum. A held check just before each strobe separates a pixel counter that holds on the last pixel from one that wraps.

// File: rtl/bgt_pkg.sv
package bgt_pkg;
    localparam int COL_W   = 4;
    localparam int WSEL_W  = 2;
    localparam int ROW_W   = 4;
    localparam int LINE_W  = 4;
    localparam int HMAP_W  = 7;
    localparam int CODE_W  = 7;
    localparam int NIB_W   = 4;
    localparam int NPIX    = 6;
    localparam int BANK_W  = 6;
    localparam int HPOS_W  = COL_W + WSEL_W;
    localparam int VPOS_W  = ROW_W + LINE_W;
    localparam int MAP_AW  = ROW_W + HMAP_W;
    localparam int ENTRY_W = CODE_W + 1;
    localparam int ROM_AW  = CODE_W + LINE_W + WSEL_W;
    localparam int WORD_W  = NPIX * NIB_W;
    localparam int IDX_W   = $clog2(NPIX);

    typedef struct packed {
        logic              mirror;
        logic [CODE_W-1:0] code;
    } map_entry_t;

    typedef struct packed {
        logic [WSEL_W-1:0] wsel;
        logic [LINE_W-1:0] line;
    } slot_meta_t;

    function automatic logic [MAP_AW-1:0] map_addr_f(
        input logic [COL_W-1:0]  col,
        input logic [ROW_W-1:0]  row,
        input logic [HMAP_W-1:0] scr);
        logic [HMAP_W-1:0] hsum;
        hsum = HMAP_W'(col) + scr;
        return {row, hsum};
    endfunction

    function automatic logic [ROM_AW-1:0] rom_addr_f(
        input map_entry_t ent,
        input slot_meta_t meta);
        logic [WSEL_W-1:0] w;
        w = ent.mirror ? ~meta.wsel : meta.wsel;
        return {ent.code, meta.line, w};
    endfunction
endpackage

// File: rtl/bgt_map_fetch.sv
module bgt_map_fetch
    import bgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_stb,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [VPOS_W-1:0] vpos,
    input  logic [HMAP_W-1:0] scroll,
    output logic [MAP_AW-1:0] map_addr,
    output slot_meta_t        meta_q
);
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    slot_meta_t       meta_d;

    always_comb begin
        col         = hpos[HPOS_W-1:WSEL_W];
        row         = vpos[VPOS_W-1:LINE_W];
        meta_d.wsel = hpos[WSEL_W-1:0];
        meta_d.line = vpos[LINE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            map_addr <= '0;
            meta_q   <= '0;
        end else if (word_stb) begin
            map_addr <= map_addr_f(col, row, scroll);
            meta_q   <= meta_d;
        end
    end

    // R6
    map_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_stb |=> $stable(map_addr));
endmodule

// File: rtl/bgt_rom_fetch.sv
module bgt_rom_fetch
    import bgt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               word_stb,
    input  slot_meta_t         meta_in,
    input  logic [ENTRY_W-1:0] map_data,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               mirror_q
);
    map_entry_t ent;

    always_comb ent = map_entry_t'(map_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            rom_addr <= '0;
            mirror_q <= 1'b0;
        end else if (word_stb) begin
            rom_addr <= rom_addr_f(ent, meta_in);
            mirror_q <= ent.mirror;
        end
    end

    // R6
    rom_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_stb |=> $stable(rom_addr));
endmodule

// File: rtl/bgt_pix_shift.sv
module bgt_pix_shift
    import bgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              word_stb,
    input  logic [WORD_W-1:0] rom_word,
    input  logic              mirror_in,
    input  logic [BANK_W-1:0] bank_in,
    output logic [NIB_W-1:0]  pix_index,
    output logic [BANK_W-1:0] pix_bank
);
    logic [WORD_W-1:0] rev_word;
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic              at_last;

    for (genvar g = 0; g < NPIX; g++) begin : g_rev
        assign rev_word[g*NIB_W +: NIB_W] = rom_word[(NPIX-1-g)*NIB_W +: NIB_W];
    end

    assign at_last = (idx_q == IDX_W'(NPIX-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            idx_q    <= '0;
            pix_bank <= '0;
        end else if (word_stb) begin
            word_q   <= mirror_in ? rev_word : rom_word;
            idx_q    <= '0;
            pix_bank <= bank_in;
        end else if (!at_last) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    assign pix_index = word_q[(NPIX-1-int'(idx_q))*NIB_W +: NIB_W];

    // R8
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        idx_q < IDX_W'(NPIX));
    // R8
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_stb && !at_last) |=> idx_q == $past(idx_q) + 1'b1);
    // R8
    idx_start_chk: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> idx_q == '0);
    // R7
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !word_stb |=> $stable(pix_bank));
endmodule

// File: rtl/bg_tile_gen.sv
module bg_tile_gen
    import bgt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               word_stb,
    input  logic [HPOS_W-1:0]  hpos,
    input  logic [VPOS_W-1:0]  vpos,
    input  logic [HMAP_W-1:0]  scroll,
    input  logic [BANK_W-1:0]  bank_sel,
    output logic [MAP_AW-1:0]  map_addr,
    input  logic [ENTRY_W-1:0] map_data,
    output logic [ROM_AW-1:0]  rom_addr,
    input  logic [WORD_W-1:0]  rom_data,
    output logic [NIB_W-1:0]   pix_index,
    output logic [BANK_W-1:0]  pix_bank
);
    slot_meta_t meta_a;
    logic       mirror_b;

    bgt_map_fetch u_map (
        .clk(clk), .rst(rst), .word_stb(word_stb),
        .hpos(hpos), .vpos(vpos), .scroll(scroll),
        .map_addr(map_addr), .meta_q(meta_a)
    );

    bgt_rom_fetch u_rom (
        .clk(clk), .rst(rst), .word_stb(word_stb),
        .meta_in(meta_a), .map_data(map_data),
        .rom_addr(rom_addr), .mirror_q(mirror_b)
    );

    bgt_pix_shift u_pix (
        .clk(clk), .rst(rst), .word_stb(word_stb),
        .rom_word(rom_data), .mirror_in(mirror_b), .bank_in(bank_sel),
        .pix_index(pix_index), .pix_bank(pix_bank)
    );

    // R10
    stb_gap_chk: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb);
endmodule

// File: tb/sim_bg_tile_gen.sv
module sim_bg_tile_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        word_stb = 1'b0;
    logic [5:0]  hpos = '0;
    logic [7:0]  vpos = '0;
    logic [6:0]  scroll = '0;
    logic [5:0]  bank_sel = '0;
    logic [10:0] map_addr;
    logic [7:0]  map_data = '0;
    logic [12:0] rom_addr;
    logic [23:0] rom_data = '0;
    logic [3:0]  pix_index;
    logic [5:0]  pix_bank;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int nslot = 0;
    int nmirror = 0;

    typedef struct {
        logic [5:0] h;
        logic [7:0] v;
        logic [6:0] s;
        logic [5:0] b;
    } iss_t;
    iss_t p1, p2, p3;

    bg_tile_gen u0 (
        .clk(clk), .rst(rst), .word_stb(word_stb), .hpos(hpos), .vpos(vpos),
        .scroll(scroll), .bank_sel(bank_sel), .map_addr(map_addr),
        .map_data(map_data), .rom_addr(rom_addr), .rom_data(rom_data),
        .pix_index(pix_index), .pix_bank(pix_bank)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] fmap(input logic [10:0] a);
        logic [31:0] x;
        x = {21'd0, a} * 32'd2654435761;
        return x[23:16] ^ x[7:0];
    endfunction

    function automatic logic [23:0] from(input logic [12:0] a);
        logic [31:0] x;
        x = ({19'd0, a} + 32'd77) * 32'd2246822519;
        return x[31:8] ^ {x[7:0], x[7:0], x[7:0]};
    endfunction

    always @(posedge clk) begin
        map_data <= fmap(map_addr);
        rom_data <= from(rom_addr);
    end

    function automatic logic [10:0] exp_maddr(input iss_t t);
        logic [6:0] hs;
        hs = 7'(t.h[5:2]) + t.s;
        return {t.v[7:4], hs};
    endfunction

    function automatic logic exp_mirror(input iss_t t);
        logic [7:0] e;
        e = fmap(exp_maddr(t));
        return e[7];
    endfunction

    function automatic logic [12:0] exp_raddr(input iss_t t);
        logic [7:0] e;
        logic [1:0] w;
        e = fmap(exp_maddr(t));
        w = e[7] ? ~t.h[1:0] : t.h[1:0];
        return {e[6:0], t.v[3:0], w};
    endfunction

    function automatic logic [3:0] exp_nib(input iss_t t, input int i);
        logic [23:0] w;
        w = from(exp_raddr(t));
        return exp_mirror(t) ? w[4*i +: 4] : w[23-4*i -: 4];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pix_chk(input iss_t t, input int i);
        string r;
        r = exp_mirror(t) ? "R5" : "R4";
        chk(pix_index == exp_nib(t, i), r, pix_index, exp_nib(t, i));
    endtask

    task automatic run_slot(input logic [5:0] h, input logic [7:0] v,
                            input logic [6:0] s, input logic [5:0] b);
        iss_t cur;
        cur.h = h; cur.v = v; cur.s = s; cur.b = b;
        @(negedge clk);
        // R8: last pixel of the previous word still held
        if (nslot >= 3) pix_chk(p3, 5);
        word_stb = 1'b1; hpos = h; vpos = v; scroll = s; bank_sel = b;
        @(negedge clk);
        word_stb = 1'b0;
        hpos = 6'($urandom); vpos = 8'($urandom); scroll = 7'($urandom); bank_sel = 6'($urandom);
        // R1
        chk(map_addr == exp_maddr(cur), "R1", map_addr, exp_maddr(cur));
        if (nslot >= 1) begin
            if (exp_mirror(p1)) begin
                nmirror++;
                chk(rom_addr == exp_raddr(p1), "R3", rom_addr, exp_raddr(p1));
            end else begin
                chk(rom_addr == exp_raddr(p1), "R2", rom_addr, exp_raddr(p1));
            end
        end
        if (nslot >= 2) begin
            // R6: slot k pixels after strobe k+2
            pix_chk(p2, 0);
            chk(pix_bank == b, "R7", pix_bank, b);
        end
        for (int i = 1; i < 6; i++) begin
            @(negedge clk);
            if (nslot >= 2) pix_chk(p2, i);
            if (i == 3) begin
                chk(map_addr == exp_maddr(cur), "R6", map_addr, exp_maddr(cur));
                if (nslot >= 2) chk(pix_bank == b, "R7", pix_bank, b);
            end
        end
        p3 = p2; p2 = p1; p1 = cur;
        nslot++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9
        chk(map_addr == '0, "R9", map_addr, 0);
        chk(rom_addr == '0, "R9", rom_addr, 0);
        chk(pix_index == '0, "R9", pix_index, 0);
        chk(pix_bank == '0, "R9", pix_bank, 0);
        rst = 1'b0;
        // scroll wrap corner cases (R1)
        run_slot(6'h3C, 8'h21, 7'd127, 6'h01);
        run_slot(6'h3F, 8'h5A, 7'd113, 6'h3F);
        run_slot(6'h00, 8'hF0, 7'd0,   6'h15);
        run_slot(6'h27, 8'h0F, 7'd120, 6'h2A);
        for (int k = 0; k < 64; k++)
            run_slot(6'(k), 8'h37, 7'd5, 6'(k));
        for (int k = 0; k < 200; k++)
            run_slot(6'($urandom), 8'($urandom), 7'($urandom), 6'($urandom));
        chk(nmirror > 0, "R3", nmirror, 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule